// File: doc/BRIEF.md
# 64-bit Event Timer with One-Shot and Periodic Modes

This block is a memory-mapped timer peripheral that generates timed events for a processor. A 64-bit up-counter and a 64-bit period value are each reached as two 32-bit words through a simple register port. A two-bit mode field picks whether the counter is stopped, runs once until it meets the period, or restarts from zero on every match.

Software first opens the run gate in the global control word. It then loads the count and period while the mode is zero, enables the interrupt, and writes a non-zero mode to start. Each match raises a one-cycle event pulse. When interrupts are enabled, the match also sets a sticky status bit that drives the interrupt level until software clears it.

The register port is combinational on reads and takes writes on the clock edge while select and write are both high. Addresses that no register decodes read as zero.

Top module: `evt_tmr`

## Requirements
- R1: After reset every register reads 0 and `evt_o` and `irq_o` are low.
- R2: The counter runs only while bits [1:0] of the global control word (offset 0x24) are both 1. Otherwise it is forced to 0 on every clock. Writes to the count words are ignored and no event is produced.
- R3: The count is read and written as low word 0x10 and high word 0x14, and the period as low word 0x18 and high word 0x1C. Reads return the live count, and the carry from the low word propagates into the high word.
- R4: With timer control (offset 0x20) bits [7:6] = 01, the counter rises by one per clock. In the cycle it equals the period, `evt_o` is high for exactly one cycle. On the next clock the mode field becomes 00 and the counter holds the matched value.
- R5: When the mode field is cleared, by hardware or by software, counting stops at once. All other timer control bits keep their value.
- R6: With the mode field at 10 or 11, a match sends the counter to 0 on the next clock and counting continues. Events therefore repeat every period+1 clocks.
- R7: In the interrupt word (offset 0x44), bit 0 is the enable and bit 1 is a sticky status bit. The status bit is set on an event while the enable is 1, and `irq_o` follows it. Writing 1 to bit 1 clears it. A set in the same cycle wins over the clear.
- R8: While the interrupt enable is 0, events leave the status bit and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address |
| evt_o | output | 1 | One-cycle pulse on each count/period match |
| irq_o | output | 1 | Interrupt level from the sticky status bit |

## Verification
The bench builds the block with its defaults: 32-bit words, a 64-bit count and 8-bit addresses. It therefore exercises the real word split, including a carry from the low into the high count word. Periods of only a few clocks let several periodic wraps, a one-shot stop and the masked and unmasked interrupt paths fit into a short run. The bench predicts every event cycle from the enable-write edge and the period, and it flags any pulse that arrives early, late or without a prediction.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    // register byte offsets
    localparam int CNT_BASE = 'h10;
    localparam int TCR_OFS  = 'h20;
    localparam int GCR_OFS  = 'h24;
    localparam int INT_OFS  = 'h44;

    // mode field placement inside timer control
    localparam int MODE_LSB = 6;
    // width of the run gate in global control
    localparam int GATE_W   = 2;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ONCE = 2'b01,
        MODE_LOOP = 2'b10,
        MODE_ALT  = 2'b11
    } mode_e;

endpackage

// File: rtl/evt_tmr_count.sv
module evt_tmr_count #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          gate_i,
    input  logic [1:0]                    mode_i,
    input  logic [CNT_W/DATA_W-1:0]       cnt_we_i,
    input  logic [CNT_W/DATA_W-1:0]       prd_we_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [CNT_W-1:0]              cnt_o,
    output logic [CNT_W-1:0]              prd_o,
    output logic                          match_o
);
    localparam int NSEG = CNT_W / DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
    } st_t;

    st_t s_d, s_q;

    logic [CNT_W-1:0] cnt_mask;
    logic [CNT_W-1:0] prd_mask;
    logic [CNT_W-1:0] wide_wdata;
    logic             active;
    logic             match;

    assign wide_wdata = {NSEG{wdata_i}};

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        assign cnt_mask[k*DATA_W +: DATA_W] = {DATA_W{cnt_we_i[k]}};
        assign prd_mask[k*DATA_W +: DATA_W] = {DATA_W{prd_we_i[k]}};
    end

    assign active = gate_i && (mode_i != 2'b00);
    assign match  = active && (s_q.cnt == s_q.prd);

    always_comb begin
        s_d     = s_q;
        s_d.prd = (s_q.prd & ~prd_mask) | (wide_wdata & prd_mask);
        if (!gate_i) begin
            s_d.cnt = '0;
        end else if (|cnt_we_i) begin
            s_d.cnt = (s_q.cnt & ~cnt_mask) | (wide_wdata & cnt_mask);
        end else if (match) begin
            // loop modes restart, single mode holds the matched value
            if (mode_i[1]) s_d.cnt = '0;
        end else if (active) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign prd_o   = s_q.prd;
    assign match_o = match;

endmodule

// File: rtl/evt_tmr_irq.sv
module evt_tmr_irq (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  logic [1:0] wdata_i,
    input  logic       evt_i,
    output logic       ien_o,
    output logic       sts_o
);
    typedef struct packed {
        logic ien;
        logic sts;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) s_d.ien = wdata_i[0];
        if (evt_i && s_q.ien)       s_d.sts = 1'b1;
        else if (we_i && wdata_i[1]) s_d.sts = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ien_o = s_q.ien;
    assign sts_o = s_q.sts;

endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
    import evt_tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              evt_o,
    output logic              irq_o
);
    localparam int NSEG     = CNT_W / DATA_W;
    localparam int PRD_BASE = CNT_BASE + 4 * NSEG;

    typedef struct packed {
        logic [DATA_W-1:0] tcr;
        logic [GATE_W-1:0] gcr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             wr;
    logic [NSEG-1:0]  cnt_we;
    logic [NSEG-1:0]  prd_we;
    logic             tcr_we;
    logic             gcr_we;
    logic             int_we;
    logic             gate;
    mode_e            mode;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] prd_val;
    logic             match;
    logic             ien;
    logic             sts;

    assign wr     = bus_sel_i && bus_wr_i;
    assign tcr_we = wr && (bus_addr_i == ADDR_W'(TCR_OFS));
    assign gcr_we = wr && (bus_addr_i == ADDR_W'(GCR_OFS));
    assign int_we = wr && (bus_addr_i == ADDR_W'(INT_OFS));

    for (genvar k = 0; k < NSEG; k++) begin : g_dec
        assign cnt_we[k] = wr && (bus_addr_i == ADDR_W'(CNT_BASE + 4 * k));
        assign prd_we[k] = wr && (bus_addr_i == ADDR_W'(PRD_BASE + 4 * k));
    end

    assign mode = mode_e'(ctl_q.tcr[MODE_LSB +: 2]);
    assign gate = &ctl_q.gcr;

    always_comb begin
        ctl_d = ctl_q;
        if (tcr_we) begin
            ctl_d.tcr = bus_wdata_i;
        end else if (match && (mode == MODE_ONCE)) begin
            ctl_d.tcr[MODE_LSB +: 2] = MODE_OFF;
        end
        if (gcr_we) ctl_d.gcr = bus_wdata_i[GATE_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    evt_tmr_count #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .gate_i   (gate),
        .mode_i   (mode),
        .cnt_we_i (cnt_we),
        .prd_we_i (prd_we),
        .wdata_i  (bus_wdata_i),
        .cnt_o    (cnt_val),
        .prd_o    (prd_val),
        .match_o  (match)
    );

    evt_tmr_irq u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (int_we),
        .wdata_i (bus_wdata_i[1:0]),
        .evt_i   (match),
        .ien_o   (ien),
        .sts_o   (sts)
    );

    always_comb begin
        bus_rdata_o = '0;
        for (int k = 0; k < NSEG; k++) begin
            if (bus_addr_i == ADDR_W'(CNT_BASE + 4 * k)) bus_rdata_o = cnt_val[k*DATA_W +: DATA_W];
            if (bus_addr_i == ADDR_W'(PRD_BASE + 4 * k)) bus_rdata_o = prd_val[k*DATA_W +: DATA_W];
        end
        if (bus_addr_i == ADDR_W'(TCR_OFS)) bus_rdata_o = ctl_q.tcr;
        if (bus_addr_i == ADDR_W'(GCR_OFS)) bus_rdata_o = DATA_W'(ctl_q.gcr);
        if (bus_addr_i == ADDR_W'(INT_OFS)) bus_rdata_o = DATA_W'({sts, ien});
    end

    assign evt_o = match;
    assign irq_o = sts;

endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt,
    input logic             irq,
    input logic [1:0]       mode,
    input logic             gate,
    input logic [CNT_W-1:0] cnt,
    input logic             ien,
    input logic             tcr_wr,
    input logic             cnt_wr
);
    // R2
    held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> (cnt == '0));

    // R2
    evt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> gate);

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode == 2'b01 && !tcr_wr) |=> (mode == 2'b00 && $stable(cnt)));

    // R6
    periodic_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode[1] && !cnt_wr) |=> (cnt == '0));

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ien) |=> irq);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && !irq) |=> !irq);

endmodule

bind evt_tmr evt_tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .evt    (evt_o),
    .irq    (irq_o),
    .mode   (mode),
    .gate   (gate),
    .cnt    (cnt_val),
    .ien    (ien),
    .tcr_wr (tcr_we),
    .cnt_wr (|cnt_we)
);

// File: tb/evt_tmr_tb_top.sv
`timescale 1ns/1ps
module evt_tmr_tb_top;
    localparam logic [7:0] A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18, A_PHI = 8'h1C;
    localparam logic [7:0] A_TCR = 8'h20, A_GCR = 8'h24, A_INT = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wrs = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt, irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_tmr dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wrs),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .evt_o(evt), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int edge_n);
        sel = 1'b1; wrs = 1'b1; addr = a; wdata = d;
        edge_n = cyc + 1;
        @(negedge clk);
        sel = 1'b0; wrs = 1'b0;
    endtask

    task automatic w(input logic [7:0] a, input logic [31:0] d);
        int e;
        wr(a, d, e);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: each event pulse must match the oldest predicted cycle
    always @(negedge clk) begin
        if (rst_n && evt) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R4/R6 event: actual cycle %0d expected none", cyc);
            end else begin
                chk("R6 event cycle", 64'(cyc), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        int we;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rchk("R1 cnt lo", A_CLO, 0); rchk("R1 cnt hi", A_CHI, 0);
        rchk("R1 prd lo", A_PLO, 0); rchk("R1 prd hi", A_PHI, 0);
        rchk("R1 tcr", A_TCR, 0);    rchk("R1 gcr", A_GCR, 0);
        rchk("R1 int", A_INT, 0);
        chk("R1 irq", irq, 0); chk("R1 evt", evt, 0);

        // R2 gate closed: counter held, writes ignored, no events
        idle(1);
        w(A_PLO, 5); w(A_CLO, 7); w(A_TCR, 32'h40);
        idle(20);
        rchk("R2 held with gate 00", A_CLO, 0);
        w(A_GCR, 1);
        idle(10);
        rchk("R2 held with gate 01", A_CLO, 0);
        w(A_TCR, 0); w(A_GCR, 3);

        // R4 one-shot, R5 other bits kept, R7 interrupt
        w(A_CLO, 0); w(A_CHI, 0); w(A_PLO, 4); w(A_PHI, 0); w(A_INT, 1);
        wr(A_TCR, 32'h45, we); exp_q.push_back(we + 4);
        idle(10);
        rchk("R5 tcr after one-shot", A_TCR, 32'h05);
        rchk("R4 count holds match", A_CLO, 4);
        chk("R7 irq set", irq, 1);
        rchk("R7 status read", A_INT, 3);
        w(A_INT, 3);
        chk("R7 irq cleared", irq, 0);

        // R6 periodic mode 10, four wraps, then software stop
        w(A_CLO, 0); w(A_PLO, 3);
        wr(A_TCR, 32'h80, we);
        for (int j = 0; j < 4; j++) exp_q.push_back(we + 3 + 4 * j);
        idle(16);
        w(A_TCR, 0);
        rchk("R6 count after stop", A_CLO, 1);
        idle(5);
        rchk("R5 count frozen", A_CLO, 1);
        w(A_INT, 3);

        // R6 mode 11 behaves as periodic
        w(A_CLO, 0); w(A_PLO, 2);
        wr(A_TCR, 32'hC0, we);
        exp_q.push_back(we + 2); exp_q.push_back(we + 5);
        idle(5);
        w(A_TCR, 0);
        rchk("R5 tcr cleared", A_TCR, 0);
        w(A_INT, 3);
        chk("R7 irq cleared again", irq, 0);

        // R8 masked interrupt
        w(A_INT, 0);
        w(A_CLO, 0); w(A_PLO, 2);
        wr(A_TCR, 32'h40, we); exp_q.push_back(we + 2);
        idle(6);
        chk("R8 irq masked", irq, 0);
        rchk("R8 status masked", A_INT, 0);

        // R3 carry across halves and 64-bit match
        w(A_CLO, 32'hFFFF_FFFE); w(A_CHI, 0); w(A_PLO, 0); w(A_PHI, 1);
        wr(A_TCR, 32'h40, we); exp_q.push_back(we + 2);
        idle(4);
        rchk("R3 cnt hi carry", A_CHI, 1);
        rchk("R3 cnt lo wrapped", A_CLO, 0);
        rchk("R3 prd hi", A_PHI, 1);

        // R3 live count, R2 gate closing clears a running counter
        w(A_CLO, 0); w(A_CHI, 0); w(A_PHI, 0); w(A_PLO, 1000);
        wr(A_TCR, 32'h80, we);
        idle(7);
        rchk("R3 live count", A_CLO, 7);
        w(A_GCR, 0);
        idle(1);
        rchk("R2 cleared by gate", A_CLO, 0);
        w(A_TCR, 0);

        idle(3);
        chk("R4 R6 all events seen", 64'(exp_q.size()), 0);
        summary();
    end
endmodule